// File: doc/BRIEF.md
# Three-Level Address Translation Walker

This block turns a 32-bit logical address into a physical address by walking a tree of 4-byte descriptors held in memory. The tree has up to three levels. Each level is indexed by a 4-bit field of the logical address, taken from the top down. A descriptor at any level may end the walk as a page. The page size then follows from the depth at which the walk stopped: 256 MB at the first level, 16 MB at the second, 1 MB at the third.

A client offers a logical address and a write flag on a valid/ready request channel. The walker reads descriptors through a single memory port with a fixed one-cycle read latency. Along the way it writes back the used bit of every descriptor it follows, and sets the modified bit of the final page on a write. The result leaves on a valid/ready response channel: the physical address, the cache-inhibit flag and a fault flag. Only one walk is in flight at a time. The first-level table base comes from a root pointer input.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0.
- R2: Descriptor type is its bits 1:0. Value 01 is a page, value 10 is a table pointer whose base is bits 31:4 with the low four bits cleared. The entry address is the table base plus 4 times the level index. The level indices are logical bits 31:28, 27:24 and 23:20.
- R3: A page found at the third level yields {desc[31:20], laddr[19:0]}.
- R4: A page found at the second level yields {desc[31:24], laddr[23:0]}.
- R5: A page found at the first level yields {desc[31:28], laddr[27:0]}.
- R6: `rsp_ci` equals bit 6 of the terminating page descriptor.
- R7: A descriptor of type 00 or 11 ends the walk with `rsp_fault`=1, `rsp_paddr`=0 and `rsp_ci`=0. That descriptor is not written.
- R8: A table pointer (type 10) met at the third level is a fault, and that descriptor is not written.
- R9: Every descriptor followed on a successful walk has its used bit (bit 3) set in memory when the response appears. A write is issued only if the bit was clear.
- R10: On a write request, the terminating page descriptor also gets its modified bit (bit 4) set. Table descriptors and read walks never set bit 4.
- R11: Two upper entries may point at the same lower table, and walks through either entry reach the same lower descriptors.
- R12: `req_ready` is 0 while a walk is in progress. A response with `rsp_ready` low keeps its valid and data unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Base address of the first-level table |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_laddr | input | 32 | Logical address to translate |
| req_write | input | 1 | Access is a write (sets modified bit) |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Client takes result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_ci | output | 1 | Cache-inhibit of the terminating page |
| rsp_fault | output | 1 | Walk failed |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the descriptor |
| mem_wdata | output | 32 | Updated descriptor |
| mem_rdata | input | 32 | Read data, one cycle after a read strobe |

## Verification
The bench builds a tree in which the first-level and second-level tables contain both pages and pointers. It places an invalid entry at each of two levels, a pointer at the third level, and a second-level entry that reuses the third-level table. Each of these faults needs its own check. A walker that ignored the depth would splice the wrong number of low bits. One that honoured a third-level pointer would read past the tree. One that wrote faulting descriptors would corrupt them with a used bit. The bench also checks that the modified bit lands only on the final page of a write, and that a held response stays steady when the client stalls.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [1:0] {
    DT_INVALID = 2'b00,
    DT_PAGE    = 2'b01,
    DT_TABLE   = 2'b10,
    DT_RSVD    = 2'b11
  } desc_type_e;

  localparam int USED_BIT  = 3;
  localparam int MOD_BIT   = 4;
  localparam int CI_BIT    = 6;
  localparam int ALIGN_LSB = 4;  // table bases are 16-byte aligned
endpackage

// File: rtl/xw_index.sv
module xw_index #(
  parameter int AW     = 32,
  parameter int IDX_W  = 4,
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2
) (
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    laddr,
  input  logic [LVL_W-1:0] level,
  output logic [AW-1:0]    entry_addr
);
  import xw_pkg::*;

  logic [IDX_W-1:0] idx_arr [LEVELS];
  logic [IDX_W-1:0] idx;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_idx
      assign idx_arr[g] = laddr[AW-1-g*IDX_W -: IDX_W];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++)
      if (level == LVL_W'(i)) idx = idx_arr[i];
  end

  assign entry_addr = {base[AW-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}}
                    + {{(AW-IDX_W-2){1'b0}}, idx, 2'b00};
endmodule

// File: rtl/xw_decode.sv
module xw_decode #(
  parameter int AW     = 32,
  parameter int IDX_W  = 4,
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2
) (
  input  logic [AW-1:0]    desc,
  input  logic [AW-1:0]    laddr,
  input  logic [LVL_W-1:0] level,
  input  logic             is_write,
  output logic             is_page,
  output logic             is_table,
  output logic             is_fault,
  output logic [AW-1:0]    next_base,
  output logic [AW-1:0]    paddr,
  output logic             ci,
  output logic [AW-1:0]    new_desc,
  output logic             dirty
);
  import xw_pkg::*;

  desc_type_e       dtype;
  logic             last;
  logic [AW-1:0]    off_mask [LEVELS];
  logic [AW-1:0]    mask;

  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_mask
      assign off_mask[g] = {AW{1'b1}} >> ((g + 1) * IDX_W);
    end
  endgenerate

  always_comb begin
    mask = '0;
    for (int i = 0; i < LEVELS; i++)
      if (level == LVL_W'(i)) mask = off_mask[i];
  end

  assign dtype     = desc_type_e'(desc[1:0]);
  assign last      = (level == LVL_W'(LEVELS - 1));
  assign is_page   = (dtype == DT_PAGE);
  assign is_table  = (dtype == DT_TABLE) && !last;
  assign is_fault  = !is_page && !is_table;
  assign next_base = {desc[AW-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  assign paddr     = (desc & ~mask) | (laddr & mask);
  assign ci        = desc[CI_BIT];

  always_comb begin
    new_desc = desc;
    new_desc[USED_BIT] = 1'b1;
    if (is_page && is_write) new_desc[MOD_BIT] = 1'b1;
  end

  assign dirty = !is_fault && (new_desc != desc);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int AW     = 32,
  parameter int IDX_W  = 4,
  parameter int LEVELS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] root_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_laddr,
  input  logic          req_write,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_ci,
  output logic          rsp_fault,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata
);
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WB, S_STEP, S_RESP} state_e;

  state_e            state_q;
  logic [LVL_W-1:0]  level_q;
  logic [AW-1:0]     laddr_q, base_q, entry_addr, new_q, nbase_q, paddr_q;
  logic              write_q, page_q, fault_q, ci_q;

  logic              d_page, d_table, d_fault, d_ci, d_dirty;
  logic [AW-1:0]     d_nbase, d_paddr, d_new;

  xw_index #(.AW(AW), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_index (
    .base(base_q), .laddr(laddr_q), .level(level_q), .entry_addr(entry_addr)
  );

  xw_decode #(.AW(AW), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_decode (
    .desc(mem_rdata), .laddr(laddr_q), .level(level_q), .is_write(write_q),
    .is_page(d_page), .is_table(d_table), .is_fault(d_fault),
    .next_base(d_nbase), .paddr(d_paddr), .ci(d_ci),
    .new_desc(d_new), .dirty(d_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      level_q   <= '0;
      laddr_q   <= '0;
      base_q    <= '0;
      write_q   <= 1'b0;
      new_q     <= '0;
      nbase_q   <= '0;
      paddr_q   <= '0;
      page_q    <= 1'b0;
      fault_q   <= 1'b0;
      ci_q      <= 1'b0;
      rsp_paddr <= '0;
      rsp_ci    <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          laddr_q <= req_laddr;
          write_q <= req_write;
          base_q  <= root_base;
          level_q <= '0;
          state_q <= S_RD;
        end
        S_RD: state_q <= S_WAIT;
        S_WAIT: begin
          new_q   <= d_new;
          nbase_q <= d_nbase;
          paddr_q <= d_paddr;
          page_q  <= d_page;
          fault_q <= d_fault;
          ci_q    <= d_ci;
          state_q <= d_dirty ? S_WB : S_STEP;
        end
        S_WB: state_q <= S_STEP;
        S_STEP: begin
          if (fault_q) begin
            rsp_paddr <= '0;
            rsp_ci    <= 1'b0;
            rsp_fault <= 1'b1;
            state_q   <= S_RESP;
          end else if (page_q) begin
            rsp_paddr <= paddr_q;
            rsp_ci    <= ci_q;
            rsp_fault <= 1'b0;
            state_q   <= S_RESP;
          end else begin
            base_q  <= nbase_q;
            level_q <= level_q + 1'b1;
            state_q <= S_RD;
          end
        end
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign rsp_valid = (state_q == S_RESP);
  assign mem_en    = (state_q == S_RD) || (state_q == S_WB);
  assign mem_we    = (state_q == S_WB);
  assign mem_addr  = entry_addr;
  assign mem_wdata = new_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_paddr,
  input logic          rsp_ci,
  input logic          rsp_fault,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_wdata
);
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_ci) && $stable(rsp_fault));

  p_busy_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && !rsp_ci);

  p_wb_used_r9: assert property (@(posedge clk) disable iff (rst)
    mem_en && mem_we |-> mem_wdata[3]);

  p_wb_valid_r7: assert property (@(posedge clk) disable iff (rst)
    mem_en && mem_we |-> (mem_wdata[1:0] == 2'b01 || mem_wdata[1:0] == 2'b10));

  p_mem_idle_r12: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_en);
endmodule

bind xlat_walker xlat_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci),
  .rsp_fault(rsp_fault), .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata)
);

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] root_base = 32'h100;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_ci, rsp_fault;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  always #10 clk = ~clk;  // 50 MHz

  xlat_walker u_xlat_walker (
    .clk(clk), .rst(rst), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci), .rsp_fault(rsp_fault),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // descriptor memory: 512 words, one-cycle read latency
  logic [31:0] mem [0:511];
  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr[10:2]] <= mem_wdata;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[10:2]];
  end

  typedef struct {
    logic [31:0] paddr;
    logic        ci;
    logic        fault;
    string       tag;
  } exp_t;
  exp_t sb [$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: set rsp_ready for the coming edge, then compare if accepted there
  always @(negedge clk) begin
    cyc++;
    rsp_ready = (cyc % 3) != 0;
    if (!rst && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R12 unexpected response actual=%h expected=none", rsp_paddr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " paddr"}, rsp_paddr, e.paddr);
        check({e.tag, " ci"},    {31'b0, rsp_ci},    {31'b0, e.ci});
        check({e.tag, " fault"}, {31'b0, rsp_fault}, {31'b0, e.fault});
      end
    end
  end

  task automatic walk(logic [31:0] la, logic wr, logic [31:0] pa, logic ci,
                      logic flt, string tag);
    exp_t e;
    e.paddr = pa; e.ci = ci; e.fault = flt; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_laddr = la; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R12 busy"}, {31'b0, req_ready}, 32'd0);
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // tree: L1 @0x100 (w 0x40), L2a @0x140 (w 0x50), L2b @0x180 (w 0x60), L3 @0x1C0 (w 0x70)
    for (int i = 0; i < 512; i++) mem[i] = '0;
    for (int k = 0; k < 16; k++) begin
      mem[32'h40 + k] = (k < 8) ? ((k << 28) | 32'h1) : ((k << 28) | 32'h41);
      mem[32'h50 + k] = ((32'h40 + k) << 24) | 32'h1;
      mem[32'h60 + k] = ((32'hE0 + k) << 24) | 32'h41;
      mem[32'h70 + k] = ((32'h300 + k) << 20) | 32'h1;
    end
    mem[32'h40 + 0]  = 32'h142;        // -> L2a
    mem[32'h40 + 15] = 32'h182;        // -> L2b
    mem[32'h40 + 3]  = 32'h0;          // invalid at L1
    mem[32'h50 + 0]  = 32'h1C2;        // -> L3
    mem[32'h50 + 5]  = 32'h0;          // invalid at L2
    mem[32'h50 + 6]  = 32'h3;          // reserved type at L2
    mem[32'h60 + 15] = 32'h1C2;        // shared L3
    mem[32'h70 + 14] = 32'h142;        // pointer at L3
    mem[32'h70 + 15] = (32'h30F << 20) | 32'h41;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 req_ready", {31'b0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 mem_en",    {31'b0, mem_en},    32'd0);

    walk(32'h0023_4567, 0, 32'h3023_4567, 0, 0, "R2 R3 l3 read");
    check("R9 L1[0] used", mem[32'h40], 32'h14A);
    check("R9 L2[0] used", mem[32'h50], 32'h1CA);
    check("R9 L3[2] used", mem[32'h72], 32'h3020_0009);

    walk(32'h004A_BCDE, 1, 32'h304A_BCDE, 0, 0, "R10 l3 write");
    check("R10 L3[4] mod", mem[32'h74], 32'h3040_0019);
    check("R10 L2[0] no mod", mem[32'h50], 32'h1CA);
    walk(32'h0040_0010, 1, 32'h3040_0010, 0, 0, "R10 rewrite");
    check("R10 L3[4] keep", mem[32'h74], 32'h3040_0019);

    walk(32'h2123_4567, 0, 32'h2123_4567, 0, 0, "R5 l1 page");
    check("R9 L1[2] used", mem[32'h42], 32'h2000_0009);
    walk(32'h9ABC_DEF0, 0, 32'h9ABC_DEF0, 1, 0, "R5 R6 l1 ci");
    check("R9 L1[9]", mem[32'h49], 32'h9000_0049);
    walk(32'hA000_0004, 1, 32'hA000_0004, 1, 0, "R10 l1 write");
    check("R10 L1[10]", mem[32'h4A], 32'hA000_0059);

    walk(32'h0712_3456, 1, 32'h4712_3456, 0, 0, "R4 l2 page");
    check("R10 L2[7]", mem[32'h57], 32'h4700_0019);
    walk(32'hF33A_BCDE, 0, 32'hE33A_BCDE, 1, 0, "R4 R6 l2 ci");

    walk(32'h3000_0000, 1, 32'h0, 0, 1, "R7 l1 invalid");
    check("R7 L1[3] untouched", mem[32'h43], 32'h0);
    walk(32'h0500_0000, 0, 32'h0, 0, 1, "R7 l2 invalid");
    check("R7 L2[5] untouched", mem[32'h55], 32'h0);
    walk(32'h06FF_FFFF, 0, 32'h0, 0, 1, "R7 l2 reserved");
    check("R7 L2[6] untouched", mem[32'h56], 32'h3);

    walk(32'hFFF1_2345, 0, 32'h30F1_2345, 1, 0, "R11 shared l3");
    check("R11 L3[15]", mem[32'h7F], 32'h30F0_0049);
    check("R9 L2b[15]", mem[32'h6F], 32'h1CA);
    check("R9 L1[15]",  mem[32'h4F], 32'h18A);
    walk(32'hFF2F_FFFF, 0, 32'h302F_FFFF, 0, 0, "R11 shared hit");

    walk(32'h00E0_0000, 0, 32'h0, 0, 1, "R8 l3 pointer");
    check("R8 L3[14] untouched", mem[32'h7E], 32'h142);

    done = 1;
  end

  initial begin
    while (!done && cyc < 20000) @(negedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule